// File: doc/BRIEF.md
# Configurable UART Frame Transmitter

This block turns queued bytes into asynchronous serial frames on one output line. Bytes written through a strobe enter a 16-entry queue. A frame engine takes them one at a time and sends a low start bit, the data bits least significant first, an optional parity bit and one or two high stop bits. Every bit lasts sixteen pulses of an oversampling tick that runs at sixteen times the baud rate. The tick comes from outside the block.

A 7-bit format word sets the frame shape while the block runs. Bits [1:0] set the character length. Bit 2 sets the stop count. Bit 3 enables parity and bits [5:4] pick the parity kind. Bit 6 forces a break. The engine copies the format when it takes a character from the queue, so a character in flight keeps the shape it started with.

An enable input gates the draining of the queue at character boundaries. A clear pulse empties the queue. Two flags report whether the queue is empty and whether the whole transmitter is idle.

The frame engine has five states:

| State | Line level | Leaves when | Goes to |
|---|---|---|---|
| IDLE | high | load: enabled, queue non-empty, no break, no clear | START |
| START | low | one bit time ends | DATA |
| DATA | data bits, shifting one per bit time | the last data bit ends | PARITY if parity is on, otherwise STOP |
| PARITY | parity bit | its bit time ends | STOP |
| STOP | high | the last stop bit ends | IDLE |

Top module: `uart_frame_tx`

## Requirements
- R1: A frame is a 0 start bit, then the data bits least significant first, then the parity bit when enabled, then the stop bits at 1. Each bit holds for exactly 16 tick pulses, and `txd` is 1 while idle.
- R2: `line_ctrl[1:0]` selects the character length: 00 gives 5 bits, 01 gives 6, 10 gives 7 and 11 gives 8. Unused upper data bits are not sent.
- R3: `line_ctrl[2]` = 0 sends one stop bit and 1 sends two.
- R4: `line_ctrl[3]` = 1 inserts a parity bit, and `line_ctrl[5:4]` chooses its value:
  - 00 makes the count of ones in data plus parity odd.
  - 01 makes that count even.
  - 10 sends a constant 1.
  - 11 sends a constant 0.
- R5: While `line_ctrl[6]` is 1, `txd` is 0. No tick advances the frame and no new character starts. When the bit clears, the frame resumes where it stopped.
- R6: The queue holds 16 characters. A write while the queue is full is ignored, and the queued characters are sent in write order.
- R7: A new character starts only while `tx_enable` is 1. Dropping `tx_enable` lets the character in flight complete, and the remaining queue waits until enable returns.
- R8: A `fifo_clear` pulse empties the queue by the next cycle, and a write in the same cycle is dropped. A character already being sent still completes.
- R9: `hold_empty` is 1 exactly when the queue is empty. `tx_empty` is 1 exactly when the queue is empty and no frame is being sent.
- R10: The frame format is taken from `line_ctrl` when the character leaves the queue. A change during a frame applies from the next character.
- R11: After reset, `txd`, `hold_empty` and `tx_empty` are all 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe into the queue |
| wr_data | input | 8 | Character to queue |
| line_ctrl | input | 7 | Frame format and break control |
| tx_enable | input | 1 | Allows a new character to start |
| fifo_clear | input | 1 | Empties the queue |
| tick16 | input | 1 | Oversampling pulse, 16 per bit |
| txd | output | 1 | Serial output line |
| hold_empty | output | 1 | Queue empty |
| tx_empty | output | 1 | Queue empty and engine idle |

## Verification
The assertions check these rules on every cycle:
- The queue never holds more than its depth.
- A write into a full queue never raises the fill count.
- A clear leaves the queue empty.
- The engine stays frozen while break is set.
- The engine stays idle while enable is low.
- The data index never passes the latched character length.

Only the bench's scenarios can show the remaining behaviour:
- The serial bit values, their order and their 16-tick length.
- The parity value in each parity mode.
- The point at which a format change takes effect.
- Resumption of the frame after break.
- The completion of a character that a clear or a disable overlapped.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PARITY,
        ST_STOP
    } tx_state_t;

    typedef struct packed {
        logic       brk;
        logic [1:0] par_mode;
        logic       par_en;
        logic       two_stop;
        logic [1:0] len;
    } line_fmt_t;

    function automatic logic calc_parity(input logic [7:0] data,
                                         input logic [1:0] len,
                                         input logic [1:0] mode);
        logic [7:0] mask;
        logic       x;
        mask = 8'hFF >> (3 - len);
        x    = ^(data & mask);
        unique case (mode)
            2'b00: calc_parity = ~x;
            2'b01: calc_parity = x;
            2'b10: calc_parity = 1'b1;
            2'b11: calc_parity = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tx_queue.sv
module tx_queue #(
    parameter int WIDTH = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr, rd_ptr;
    logic [CW-1:0]    count;
    logic             do_push, do_pop;

    assign empty   = (count == '0);
    assign full    = (count == FULL_CNT);
    assign do_push = push && !full && !clr;
    assign do_pop  = pop && !empty && !clr;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else if (clr) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (do_pop)  rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        count <= FULL_CNT);

    assert_full_write_dropped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full) |=> (count <= $past(count)));

    assert_clear_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> empty);

endmodule

// File: rtl/bit_timer.sv
module bit_timer #(
    parameter int OVERSAMPLE = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  logic hold,
    output logic bit_done
);
    localparam int CW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
    localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);

    logic [CW-1:0] cnt;
    logic          step;

    assign step     = run && tick && !hold;
    assign bit_done = step && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          cnt <= '0;
        else if (!run)       cnt <= '0;
        else if (step)       cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end

    assert_hold_freezes_count_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && hold) |=> $stable(cnt));

endmodule

// File: rtl/frame_engine.sv
module frame_engine
    import uart_tx_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  line_fmt_t  fmt,
    input  logic       tx_enable,
    input  logic       q_empty,
    input  logic       q_clear,
    input  logic [7:0] q_head,
    input  logic       bit_done,
    output logic       q_pop,
    output logic       busy,
    output logic       txd
);
    tx_state_t  state_q, state_d;
    logic [7:0] shreg;
    logic [2:0] bit_idx;
    logic [1:0] len_q;
    logic       two_stop_q, par_en_q, par_bit_q, stop_idx;
    logic       load;
    logic [2:0] last_idx;

    assign load     = (state_q == ST_IDLE) && tx_enable && !q_empty && !fmt.brk && !q_clear;
    assign last_idx = {1'b0, len_q} + 3'd4;
    assign q_pop    = load;
    assign busy     = (state_q != ST_IDLE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (load) state_d = ST_START;
            ST_START:  if (bit_done) state_d = ST_DATA;
            ST_DATA:   if (bit_done && bit_idx == last_idx)
                           state_d = par_en_q ? ST_PARITY : ST_STOP;
            ST_PARITY: if (bit_done) state_d = ST_STOP;
            ST_STOP:   if (bit_done && (stop_idx || !two_stop_q)) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg      <= '0;
            bit_idx    <= '0;
            len_q      <= '0;
            two_stop_q <= 1'b0;
            par_en_q   <= 1'b0;
            par_bit_q  <= 1'b0;
            stop_idx   <= 1'b0;
        end else if (load) begin
            shreg      <= q_head;
            bit_idx    <= '0;
            len_q      <= fmt.len;
            two_stop_q <= fmt.two_stop;
            par_en_q   <= fmt.par_en;
            par_bit_q  <= calc_parity(q_head, fmt.len, fmt.par_mode);
            stop_idx   <= 1'b0;
        end else if (bit_done) begin
            if (state_q == ST_DATA) begin
                shreg   <= shreg >> 1;
                bit_idx <= bit_idx + 1'b1;
            end
            if (state_q == ST_STOP) stop_idx <= 1'b1;
        end
    end

    // output logic
    always_comb begin
        txd = 1'b1;
        if (fmt.brk) begin
            txd = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE:   txd = 1'b1;
                ST_START:  txd = 1'b0;
                ST_DATA:   txd = shreg[0];
                ST_PARITY: txd = par_bit_q;
                ST_STOP:   txd = 1'b1;
                default:   txd = 1'b1;
            endcase
        end
    end

    assert_break_freezes_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
        fmt.brk |=> $stable(state_q));

    assert_disable_holds_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !tx_enable) |=> (state_q == ST_IDLE));

    assert_data_index_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DATA) |-> (bit_idx <= last_idx));

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_tx_pkg::*;
#(
    parameter int QUEUE_DEPTH = 16,
    parameter int OVERSAMPLE  = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_en,
    input  logic [7:0] wr_data,
    input  logic [6:0] line_ctrl,
    input  logic       tx_enable,
    input  logic       fifo_clear,
    input  logic       tick16,
    output logic       txd,
    output logic       hold_empty,
    output logic       tx_empty
);
    line_fmt_t  fmt;
    logic [7:0] head;
    logic       q_empty, q_full, q_pop, busy, bit_done;

    assign fmt = line_fmt_t'(line_ctrl);

    tx_queue #(.WIDTH(8), .DEPTH(QUEUE_DEPTH)) u_queue (
        .clk(clk), .rst_n(rst_n), .clr(fifo_clear),
        .push(wr_en), .push_data(wr_data), .pop(q_pop),
        .head(head), .empty(q_empty), .full(q_full)
    );

    bit_timer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
        .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick16),
        .hold(fmt.brk), .bit_done(bit_done)
    );

    frame_engine u_engine (
        .clk(clk), .rst_n(rst_n), .fmt(fmt), .tx_enable(tx_enable),
        .q_empty(q_empty), .q_clear(fifo_clear), .q_head(head),
        .bit_done(bit_done), .q_pop(q_pop), .busy(busy), .txd(txd)
    );

    assign hold_empty = q_empty;
    assign tx_empty   = q_empty && !busy;

    assert_full_flag_not_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        q_full |-> !hold_empty);

endmodule

// File: tb/tb_uart_frame_tx.sv
module tb_uart_frame_tx;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [6:0] line_ctrl = 7'b0000011;
    logic       tx_enable = 1'b1;
    logic       fifo_clear = 1'b0;
    logic       tick16 = 1'b0;
    logic       txd, hold_empty, tx_empty;

    int tests = 0;
    int fails = 0;
    int tick_period = 1;
    int tdiv = 0;
    string cur_req = "R11";
    bit wd_fired = 1'b0;

    // reference model state
    logic [7:0] m_q[$];
    bit         m_frame[$];
    bit         m_busy = 1'b0;
    int         m_pos = 0;
    int         m_tcnt = 0;

    always #4 clk = ~clk;

    uart_frame_tx dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .line_ctrl(line_ctrl), .tx_enable(tx_enable), .fifo_clear(fifo_clear),
        .tick16(tick16), .txd(txd), .hold_empty(hold_empty), .tx_empty(tx_empty)
    );

    always @(negedge clk) begin
        if (tick_period <= 1) begin
            tick16 <= 1'b1;
        end else begin
            tick16 <= (tdiv == 0);
            tdiv   <= (tdiv + 1 >= tick_period) ? 0 : tdiv + 1;
        end
    end

    task automatic check(input string req, input string what, input logic act, input logic exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
        end
    endtask

    function automatic void start_frame(input logic [7:0] d);
        int  nb;
        bit  x;
        nb = 5 + int'(line_ctrl[1:0]);
        x  = 1'b0;
        m_frame.delete();
        m_frame.push_back(1'b0);
        for (int i = 0; i < nb; i++) begin
            m_frame.push_back(d[i]);
            x ^= d[i];
        end
        if (line_ctrl[3]) begin
            case (line_ctrl[5:4])
                2'b00: m_frame.push_back(~x);
                2'b01: m_frame.push_back(x);
                2'b10: m_frame.push_back(1'b1);
                default: m_frame.push_back(1'b0);
            endcase
        end
        m_frame.push_back(1'b1);
        if (line_ctrl[2]) m_frame.push_back(1'b1);
        m_pos  = 0;
        m_tcnt = 0;
        m_busy = 1'b1;
    endfunction

    // cycle-level reference model and per-cycle comparison
    always @(posedge clk) begin : model
        bit brk_now, full_before, load_now;
        if (!rst_n) begin
            m_q.delete();
            m_busy = 1'b0;
            m_pos  = 0;
            m_tcnt = 0;
        end else begin
            brk_now     = line_ctrl[6];
            full_before = (m_q.size() == 16);
            load_now    = !m_busy && tx_enable && m_q.size() > 0 && !brk_now && !fifo_clear;
            if (m_busy && !brk_now && tick16) begin
                m_tcnt++;
                if (m_tcnt == 16) begin
                    m_tcnt = 0;
                    m_pos++;
                    if (m_pos == m_frame.size()) m_busy = 1'b0;
                end
            end
            if (fifo_clear) begin
                m_q.delete();
            end else begin
                if (load_now) start_frame(m_q.pop_front());
                if (wr_en && !full_before) m_q.push_back(wr_data);
            end
        end
        #2;
        if (rst_n) begin
            check(cur_req, "txd", txd,
                  line_ctrl[6] ? 1'b0 : (m_busy ? m_frame[m_pos] : 1'b1));
            check("R9", "hold_empty", hold_empty, m_q.size() == 0);
            check("R9", "tx_empty", tx_empty, m_q.size() == 0 && !m_busy);
        end
    end

    task automatic put(input logic [7:0] b);
        @(negedge clk);
        wr_en = 1'b1; wr_data = b;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (m_q.size() != 0 || m_busy);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_all();
        // R11: reset values
        repeat (3) @(negedge clk);
        check("R11", "txd after reset", txd, 1'b1);
        check("R11", "hold_empty after reset", hold_empty, 1'b1);
        check("R11", "tx_empty after reset", tx_empty, 1'b1);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1, R2: 8 data bits, no parity, one stop bit
        cur_req = "R1";
        line_ctrl = 7'b0000011;
        put(8'hA5); put(8'h3C);
        wait_idle();

        // R2, R3, R4: 5 data bits, two stop bits, odd parity
        cur_req = "R4";
        line_ctrl = 7'b0001100;
        put(8'hFF); put(8'h12);
        wait_idle();
        // R4 even parity, 6 bits, slower tick
        tick_period = 2;
        line_ctrl = 7'b0011001;
        put(8'h2B);
        wait_idle();
        tick_period = 1;
        // R4 forced 1, 7 bits, two stop (R3)
        cur_req = "R3";
        line_ctrl = 7'b0101110;
        put(8'h55);
        wait_idle();
        // R4 forced 0, 8 bits
        cur_req = "R2";
        line_ctrl = 7'b0111011;
        put(8'hC3);
        wait_idle();

        // R6: fill past depth while disabled
        cur_req = "R6";
        line_ctrl = 7'b0000011;
        tx_enable = 1'b0;
        for (int i = 0; i < 17; i++) put(8'(i * 7 + 1));
        check("R6", "hold_empty when full", hold_empty, 1'b0);
        check("R7", "txd idle while disabled", txd, 1'b1);
        tx_enable = 1'b1;
        wait_idle();

        // R7: disable mid character
        cur_req = "R7";
        put(8'h81); put(8'h42); put(8'h24);
        repeat (50) @(negedge clk);
        tx_enable = 1'b0;
        repeat (400) @(negedge clk);
        check("R7", "queue still held", hold_empty, 1'b0);
        check("R7", "line idle while paused", txd, 1'b1);
        tx_enable = 1'b1;
        wait_idle();

        // R8: clear while a character is in flight, with a write in the same cycle
        cur_req = "R8";
        put(8'h11); put(8'h22); put(8'h33);
        repeat (30) @(negedge clk);
        fifo_clear = 1'b1; wr_en = 1'b1; wr_data = 8'h99;
        @(negedge clk);
        fifo_clear = 1'b0; wr_en = 1'b0;
        check("R8", "queue empty after clear", hold_empty, 1'b1);
        check("R8", "character still in flight", tx_empty, 1'b0);
        wait_idle();

        // R5: break in the middle of a character
        cur_req = "R5";
        put(8'hF0);
        repeat (70) @(negedge clk);
        line_ctrl = 7'b1000011;
        repeat (100) @(negedge clk);
        check("R5", "txd low during break", txd, 1'b0);
        line_ctrl = 7'b0000011;
        wait_idle();

        // R10: format change during a frame applies to the next character
        cur_req = "R10";
        put(8'h6E); put(8'h6E);
        repeat (40) @(negedge clk);
        line_ctrl = 7'b0001000;
        wait_idle();
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                wd_fired = 1'b1;
            end
        join_any
        disable fork;
        if (wd_fired) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=hung expected=done");
        end
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule